// File: doc/BRIEF.md
# DMA Channel Register Front End

This block is the software-visible register file of a four-channel DMA controller in the classic byte-wide I/O style. A host reaches it through sixteen 8-bit ports. Each channel has a 16-bit current address and a 16-bit current count. A host moves these one byte at a time. A shared byte pointer decides whether the low or the high half is touched, and it flips after every such access. Other ports carry a command byte, per-channel mode settings, a software request bit per channel and a mask bit per channel. Several ports act on write only: they clear the byte pointer, set or clear one mask bit, clear all masks, or perform a master clear.

A separate transfer engine reads per-channel configuration from this block. That configuration is the transfer type, the operating mode, an enable (not masked and not globally disabled), the software request and a last-transfer flag. The engine pulses a per-channel step input each time a transfer completes. The block then advances that channel's address and lowers its count. A count of N stands for N+1 transfers, so a count of zero means one transfer is left.

Top module: `dmaRegFront`

## Requirements
- R1: Channel c (0..3) has its address register at port 2c and its count register at port 2c+1. Reading these ports returns the current value, one byte per access.
- R2: The byte pointer starts at low. Every read or write of ports 0..7 uses the low byte when the pointer is clear and the high byte when it is set, then flips the pointer. Any write to port 0Ch clears the pointer whatever the data.
- R3: A write to port 0Bh targets the channel in data bits 1:0. Bits 3:2 go to that channel's type output (00 verify, 01 write to memory, 10 read from memory). Bits 7:6 go to its mode output (00 demand, 01 single, 10 block, 11 cascade). Other channels keep their settings.
- R4: A write to port 0Ah changes one mask bit. Data bits 1:0 name the channel, and bit 2 is the new mask value (1 masked).
- R5: After reset, and one cycle after any write to port 0Dh, all four masks are set. The byte pointer, command, modes, software requests, addresses and counts are all zero.
- R6: A write to port 0Eh clears all four mask bits. Reading port 0Fh returns the mask bits in bits 3:0, with zeros above.
- R7: A write to port 08h stores the command byte. While its bit 2 is set, every channel enable output is low. Otherwise channel c is enabled exactly when its mask bit is clear.
- R8: A step pulse on an enabled channel raises its address by one and lowers its count by one in the next cycle. A step on a disabled channel leaves both unchanged.
- R9: The last-transfer flag of a channel is high exactly when its count is zero. A step taken with count zero wraps the count to FFFFh.
- R10: A write to port 09h sets the software request of the channel in data bits 1:0 to data bit 2. Reading port 09h returns the four request bits in bits 3:0.
- R11: Reads of ports with no readable register return 00h and leave the byte pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioAddr | input | 4 | Port offset |
| ioWrData | input | 8 | Write data |
| ioWr | input | 1 | Write strobe, one cycle per access |
| ioRd | input | 1 | Read strobe, one cycle per access |
| ioRdData | output | 8 | Read data, valid in the cycle of ioRd |
| xferStep | input | 4 | Per-channel transfer completion pulse |
| chAddr | output | 64 | Current addresses, channel c at bits 16c+15:16c |
| chCount | output | 64 | Current counts, same packing |
| chType | output | 8 | Transfer type, 2 bits per channel |
| chMode | output | 8 | Operating mode, 2 bits per channel |
| chEnable | output | 4 | Channel may be served |
| chSwReq | output | 4 | Software request bits |
| chLast | output | 4 | Count is zero, one transfer left |

## Verification
The properties assume that the host never asserts read and write in the same cycle. One property checks this directly. They also assume the engine pulses a step only while the host is not writing. The bench drives one access per task call, each strobe held for exactly one cycle. It pulses steps only between host accesses, so the step checks never coincide with a register write.

// File: rtl/dmaRegPkg.sv
package dmaRegPkg;

  localparam int unsigned CH_W   = 2;
  localparam int unsigned NUM_CH = 1 << CH_W;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned REG_W  = 2 * BUS_W;

  localparam logic [3:0] PORT_CMD     = 4'h8;
  localparam logic [3:0] PORT_REQ     = 4'h9;
  localparam logic [3:0] PORT_MASK1   = 4'hA;
  localparam logic [3:0] PORT_MODE    = 4'hB;
  localparam logic [3:0] PORT_PTRCLR  = 4'hC;
  localparam logic [3:0] PORT_MCLR    = 4'hD;
  localparam logic [3:0] PORT_MASKCLR = 4'hE;
  localparam logic [3:0] PORT_MASKALL = 4'hF;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_ADDR,
    RD_COUNT,
    RD_MASK,
    RD_REQ
  } rdKind_e;

  typedef struct packed {
    logic            wrAddr;
    logic            wrCount;
    logic            hiByte;
    logic [CH_W-1:0] ch;
    logic            wrMode;
    logic            wrCmd;
    logic            wrReq;
    logic            wrMaskOne;
    logic            clrMaskAll;
    logic            masterClr;
    rdKind_e         rdKind;
  } regStb_t;

endpackage

// File: rtl/dmaRegCtrl.sv
module dmaRegCtrl
  import dmaRegPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       ioAddr,
  input  logic [BUS_W-1:0] ioWrData,
  input  logic             ioWr,
  input  logic             ioRd,
  output regStb_t          stb
);

  logic byteHi;
  logic chanPort;
  logic access;
  logic ptrClr;

  assign chanPort = (ioAddr[3] == 1'b0);
  assign access   = chanPort && (ioWr || ioRd);
  assign ptrClr   = ioWr && ((ioAddr == PORT_PTRCLR) || (ioAddr == PORT_MCLR));

  // byte pointer: a clear wins over a toggle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteHi <= 1'b0;
    end else if (ptrClr) begin
      byteHi <= 1'b0;
    end else if (access) begin
      byteHi <= ~byteHi;
    end
  end

  always_comb begin
    stb            = '0;
    stb.rdKind     = RD_NONE;
    stb.hiByte     = byteHi;
    stb.ch         = chanPort ? ioAddr[CH_W:1] : ioWrData[CH_W-1:0];
    if (ioWr) begin
      stb.wrAddr     = chanPort && !ioAddr[0];
      stb.wrCount    = chanPort &&  ioAddr[0];
      stb.wrCmd      = (ioAddr == PORT_CMD);
      stb.wrReq      = (ioAddr == PORT_REQ);
      stb.wrMaskOne  = (ioAddr == PORT_MASK1);
      stb.wrMode     = (ioAddr == PORT_MODE);
      stb.masterClr  = (ioAddr == PORT_MCLR);
      stb.clrMaskAll = (ioAddr == PORT_MASKCLR);
    end else if (ioRd) begin
      if (chanPort) begin
        stb.rdKind = ioAddr[0] ? RD_COUNT : RD_ADDR;
      end else if (ioAddr == PORT_MASKALL) begin
        stb.rdKind = RD_MASK;
      end else if (ioAddr == PORT_REQ) begin
        stb.rdKind = RD_REQ;
      end
    end
  end

endmodule

// File: rtl/dmaRegData.sv
module dmaRegData
  import dmaRegPkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  regStb_t                 stb,
  input  logic [BUS_W-1:0]        wrData,
  input  logic [NUM_CH-1:0]       xferStep,
  output logic [BUS_W-1:0]        rdData,
  output logic [NUM_CH*REG_W-1:0] chAddr,
  output logic [NUM_CH*REG_W-1:0] chCount,
  output logic [NUM_CH*2-1:0]     chType,
  output logic [NUM_CH*2-1:0]     chMode,
  output logic [NUM_CH-1:0]       chEnable,
  output logic [NUM_CH-1:0]       chSwReq,
  output logic [NUM_CH-1:0]       chLast
);

  localparam logic [REG_W-1:0] ONE = REG_W'(1);
  localparam int unsigned DIS_BIT = 2;

  logic [REG_W-1:0]  addrQ  [NUM_CH];
  logic [REG_W-1:0]  countQ [NUM_CH];
  logic [BUS_W-1:0]  cmdQ;
  logic [NUM_CH-1:0] maskQ;
  logic [NUM_CH-1:0] reqQ;
  logic              ctrlOff;

  assign ctrlOff = cmdQ[DIS_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ <= '0;
    end else if (stb.masterClr) begin
      cmdQ <= '0;
    end else if (stb.wrCmd) begin
      cmdQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '1;
    end else if (stb.masterClr) begin
      maskQ <= '1;
    end else if (stb.clrMaskAll) begin
      maskQ <= '0;
    end else if (stb.wrMaskOne) begin
      maskQ[stb.ch] <= wrData[2];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ <= '0;
    end else if (stb.masterClr) begin
      reqQ <= '0;
    end else if (stb.wrReq) begin
      reqQ[stb.ch] <= wrData[2];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic       sel;
    logic       stepOk;
    logic [1:0] typeQ;
    logic [1:0] modeQ;

    assign sel    = (stb.ch == CH_W'(c));
    assign stepOk = xferStep[c] && chEnable[c];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        addrQ[c] <= '0;
      end else if (stb.masterClr) begin
        addrQ[c] <= '0;
      end else if (stb.wrAddr && sel) begin
        if (stb.hiByte) addrQ[c][BUS_W +: BUS_W] <= wrData;
        else            addrQ[c][0 +: BUS_W]     <= wrData;
      end else if (stepOk) begin
        addrQ[c] <= addrQ[c] + ONE;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        countQ[c] <= '0;
      end else if (stb.masterClr) begin
        countQ[c] <= '0;
      end else if (stb.wrCount && sel) begin
        if (stb.hiByte) countQ[c][BUS_W +: BUS_W] <= wrData;
        else            countQ[c][0 +: BUS_W]     <= wrData;
      end else if (stepOk) begin
        countQ[c] <= countQ[c] - ONE;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        typeQ <= '0;
        modeQ <= '0;
      end else if (stb.masterClr) begin
        typeQ <= '0;
        modeQ <= '0;
      end else if (stb.wrMode && sel) begin
        typeQ <= wrData[3:2];
        modeQ <= wrData[7:6];
      end
    end

    assign chAddr[c*REG_W +: REG_W]  = addrQ[c];
    assign chCount[c*REG_W +: REG_W] = countQ[c];
    assign chType[c*2 +: 2]          = typeQ;
    assign chMode[c*2 +: 2]          = modeQ;
    assign chEnable[c]               = !ctrlOff && !maskQ[c];
    assign chLast[c]                 = (countQ[c] == '0);
  end

  assign chSwReq = reqQ;

  always_comb begin
    rdData = '0;
    unique case (stb.rdKind)
      RD_ADDR:  rdData = stb.hiByte ? addrQ[stb.ch][BUS_W +: BUS_W]
                                    : addrQ[stb.ch][0 +: BUS_W];
      RD_COUNT: rdData = stb.hiByte ? countQ[stb.ch][BUS_W +: BUS_W]
                                    : countQ[stb.ch][0 +: BUS_W];
      RD_MASK:  rdData = BUS_W'(maskQ);
      RD_REQ:   rdData = BUS_W'(reqQ);
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/dmaRegFront.sv
module dmaRegFront
  import dmaRegPkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [3:0]              ioAddr,
  input  logic [BUS_W-1:0]        ioWrData,
  input  logic                    ioWr,
  input  logic                    ioRd,
  output logic [BUS_W-1:0]        ioRdData,
  input  logic [NUM_CH-1:0]       xferStep,
  output logic [NUM_CH*REG_W-1:0] chAddr,
  output logic [NUM_CH*REG_W-1:0] chCount,
  output logic [NUM_CH*2-1:0]     chType,
  output logic [NUM_CH*2-1:0]     chMode,
  output logic [NUM_CH-1:0]       chEnable,
  output logic [NUM_CH-1:0]       chSwReq,
  output logic [NUM_CH-1:0]       chLast
);

  regStb_t stb;

  dmaRegCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .ioAddr   (ioAddr),
    .ioWrData (ioWrData),
    .ioWr     (ioWr),
    .ioRd     (ioRd),
    .stb      (stb)
  );

  dmaRegData uData (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (ioWrData),
    .xferStep (xferStep),
    .rdData   (ioRdData),
    .chAddr   (chAddr),
    .chCount  (chCount),
    .chType   (chType),
    .chMode   (chMode),
    .chEnable (chEnable),
    .chSwReq  (chSwReq),
    .chLast   (chLast)
  );

endmodule

// File: rtl/dmaRegChk.sv
module dmaRegChk
  import dmaRegPkg::*;
(
  input logic                    clk,
  input logic                    rstN,
  input logic [3:0]              ioAddr,
  input logic [BUS_W-1:0]        ioWrData,
  input logic                    ioWr,
  input logic                    ioRd,
  input logic [NUM_CH-1:0]       xferStep,
  input logic [NUM_CH*REG_W-1:0] chCount,
  input logic [NUM_CH-1:0]       chEnable,
  input logic [NUM_CH-1:0]       chLast
);

  // host never reads and writes at once (input assumption used by R2)
  p_one_access_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(ioWr && ioRd));

  p_mclr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioAddr == PORT_MCLR) |=> (chEnable == '0 && chCount == '0));

  p_disable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioAddr == PORT_CMD && ioWrData[2]) |=> (chEnable == '0));

  p_clrmask_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioAddr == PORT_CMD && !ioWrData[2]) ##1
    (ioWr && ioAddr == PORT_MASKCLR) |=> (chEnable == '1));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    p_step_r8: assert property (@(posedge clk) disable iff (!rstN)
      (xferStep[c] && chEnable[c] && !ioWr) |=>
      (chCount[c*REG_W +: REG_W] == $past(chCount[c*REG_W +: REG_W]) - REG_W'(1)));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
      (!chEnable[c] && !ioWr) |=> $stable(chCount[c*REG_W +: REG_W]));

    p_wrap_r9: assert property (@(posedge clk) disable iff (!rstN)
      (chLast[c] && xferStep[c] && chEnable[c] && !ioWr) |=>
      (chCount[c*REG_W +: REG_W] == '1 && !chLast[c]));
  end

endmodule

bind dmaRegFront dmaRegChk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .ioAddr   (ioAddr),
  .ioWrData (ioWrData),
  .ioWr     (ioWr),
  .ioRd     (ioRd),
  .xferStep (xferStep),
  .chCount  (chCount),
  .chEnable (chEnable),
  .chLast   (chLast)
);

// File: tb/test_dmaRegFront.sv
`timescale 1ns/100ps
module test_dmaRegFront;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  ioAddr = '0;
  logic [7:0]  ioWrData = '0;
  logic        ioWr = 1'b0;
  logic        ioRd = 1'b0;
  logic [7:0]  ioRdData;
  logic [3:0]  xferStep = '0;
  logic [63:0] chAddr;
  logic [63:0] chCount;
  logic [7:0]  chType;
  logic [7:0]  chMode;
  logic [3:0]  chEnable;
  logic [3:0]  chSwReq;
  logic [3:0]  chLast;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dmaRegFront i_dmaRegFront (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrData(ioWrData),
    .ioWr(ioWr), .ioRd(ioRd), .ioRdData(ioRdData), .xferStep(xferStep),
    .chAddr(chAddr), .chCount(chCount), .chType(chType), .chMode(chMode),
    .chEnable(chEnable), .chSwReq(chSwReq), .chLast(chLast)
  );

  // {isRead, port, data, expected}
  localparam int NV = 35;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 4'hC, 8'h55, 8'h00},  // R2 pointer clear
    {1'b0, 4'h0, 8'h34, 8'h00},  // R1 ch0 addr low
    {1'b0, 4'h0, 8'h12, 8'h00},  // R1 ch0 addr high
    {1'b0, 4'h1, 8'h03, 8'h00},  // R1 ch0 count low
    {1'b0, 4'h1, 8'h00, 8'h00},
    {1'b1, 4'h0, 8'h00, 8'h34},  // R1 readback
    {1'b1, 4'h0, 8'h00, 8'h12},
    {1'b1, 4'h1, 8'h00, 8'h03},
    {1'b1, 4'h1, 8'h00, 8'h00},
    {1'b0, 4'h2, 8'hCD, 8'h00},  // R1 ch1 addr
    {1'b0, 4'h2, 8'hAB, 8'h00},
    {1'b1, 4'h2, 8'h00, 8'hCD},
    {1'b1, 4'h2, 8'h00, 8'hAB},
    {1'b0, 4'h5, 8'h77, 8'h00},  // R2 pointer now high
    {1'b0, 4'hC, 8'hFF, 8'h00},  // R2 clear mid-sequence
    {1'b0, 4'h5, 8'h66, 8'h00},
    {1'b0, 4'h5, 8'h11, 8'h00},
    {1'b1, 4'h5, 8'h00, 8'h66},
    {1'b1, 4'h5, 8'h00, 8'h11},
    {1'b1, 4'h0, 8'h00, 8'h34},  // R11 pointer high after this
    {1'b1, 4'hE, 8'h00, 8'h00},  // R11 unreadable port
    {1'b1, 4'h0, 8'h00, 8'h12},  // R11 pointer untouched
    {1'b1, 4'hF, 8'h00, 8'h0F},  // R6 masks after reset
    {1'b0, 4'hE, 8'h00, 8'h00},  // R6 clear all
    {1'b1, 4'hF, 8'h00, 8'h00},
    {1'b0, 4'hA, 8'h06, 8'h00},  // R4 mask ch2
    {1'b1, 4'hF, 8'h00, 8'h04},
    {1'b0, 4'hA, 8'h02, 8'h00},  // R4 unmask ch2
    {1'b1, 4'hF, 8'h00, 8'h00},
    {1'b0, 4'h9, 8'h05, 8'h00},  // R10 request ch1
    {1'b1, 4'h9, 8'h00, 8'h02},
    {1'b0, 4'h9, 8'h07, 8'h00},  // R10 request ch3
    {1'b1, 4'h9, 8'h00, 8'h0A},
    {1'b0, 4'h9, 8'h01, 8'h00},  // R10 drop ch1
    {1'b1, 4'h9, 8'h00, 8'h08}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hostWr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWr = 1'b1;
    @(posedge clk); #1;
    ioWr = 1'b0;
  endtask

  task automatic hostRd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioRd = 1'b1;
    #1 d = ioRdData;
    @(posedge clk); #1;
    ioRd = 1'b0;
  endtask

  task automatic step(input int c);
    @(negedge clk);
    xferStep = 4'(1 << c);
    @(posedge clk); #1;
    xferStep = '0;
  endtask

  task automatic finish();
    $display("test done: total=%0d bad=%0d", total, bad);
    finished = 1'b1;
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      finish();
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R5 reset state
    check("R5 enable", 64'(chEnable), 64'h0);
    check("R5 count", chCount, 64'h0);
    check("R5 addr", chAddr, 64'h0);
    check("R9 last", 64'(chLast), 64'hF);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) begin
        hostRd(VEC[i][19:16], rd);
        check($sformatf("R1/R2/R6/R10/R11 vec%0d", i), 64'(rd), 64'(VEC[i][7:0]));
      end else begin
        hostWr(VEC[i][19:16], VEC[i][15:8]);
      end
    end

    // R3 mode write to ch2: type 01, mode 10
    hostWr(4'hB, 8'h86);
    @(negedge clk);
    check("R3 type", 64'(chType), 64'h10);
    check("R3 mode", 64'(chMode), 64'h20);

    // R7 command disable and restore
    check("R7 enabled", 64'(chEnable), 64'hF);
    hostWr(4'h8, 8'h04);
    @(negedge clk);
    check("R7 disabled", 64'(chEnable), 64'h0);
    hostWr(4'h8, 8'h00);
    @(negedge clk);
    check("R7 restored", 64'(chEnable), 64'hF);

    // R8 step on enabled ch0 (addr 1234, count 0003)
    step(0);
    @(negedge clk);
    check("R8 count", 64'(chCount[15:0]), 64'h0002);
    check("R8 addr", 64'(chAddr[15:0]), 64'h1235);
    hostWr(4'hA, 8'h04);
    step(0);
    @(negedge clk);
    check("R8 masked count", 64'(chCount[15:0]), 64'h0002);
    check("R8 masked addr", 64'(chAddr[15:0]), 64'h1235);
    hostWr(4'hA, 8'h00);

    // R9 last flag and wrap
    step(0);
    step(0);
    @(negedge clk);
    check("R9 zero", 64'(chCount[15:0]), 64'h0000);
    check("R9 last set", 64'(chLast[0]), 64'h1);
    step(0);
    @(negedge clk);
    check("R9 wrap", 64'(chCount[15:0]), 64'hFFFF);
    check("R9 last clear", 64'(chLast[0]), 64'h0);

    check("R10 request out", 64'(chSwReq), 64'h8);

    // R5 master clear with pointer left high
    hostWr(4'h0, 8'h99);
    hostWr(4'hD, 8'h00);
    @(negedge clk);
    check("R5 mclr enable", 64'(chEnable), 64'h0);
    check("R5 mclr count", chCount, 64'h0);
    check("R5 mclr addr", chAddr, 64'h0);
    check("R5 mclr req", 64'(chSwReq), 64'h0);
    check("R5 mclr mode", 64'({chMode, chType}), 64'h0);
    hostRd(4'hF, rd);
    check("R5 mclr masks", 64'(rd), 64'h0F);
    hostWr(4'h0, 8'h11);
    hostWr(4'h0, 8'h22);
    @(negedge clk);
    check("R5 mclr pointer", 64'(chAddr[15:0]), 64'h2211);

    finish();
  end

endmodule